// File: doc/BRIEF.md
# Privilege Mode and Segment Checker

This block sits in front of an address translation unit and screens every memory request before it reaches the TLB. Each request carries a 32-bit processor status word, a 32-bit virtual address, an access size and an access kind (instruction fetch, data load or data store). From the status word the block works out the privilege level the request runs at. From the address it decides whether the request targets one of the two unmapped kernel windows or the mapped space.

It reports a misalignment or privilege violation as a one-hot cause with an error code that tells stores apart from other accesses. It tags the request uncacheable when the address matches a fixed bit pattern. For unmapped windows it produces the physical address directly. Mapped requests leave with their virtual address and a mapped flag, so the downstream TLB can translate them.

Results are registered. There is one cycle from an accepted request to a valid result. A valid/ready handshake on both sides lets a stalled consumer hold the result.

Top module: `access_gate`

## Requirements
- R1: The resolved mode is kernel (out_mode 00) whenever status bit 28, bit 2 or bit 1 is set, or the mode field status[4:3] is 00.
- R2: With none of the override bits set, field 01 gives supervisor (out_mode 01), field 10 gives user (out_mode 10), and field 11 gives the illegal indication (out_mode 11).
- R3: With size code s (byte count 1, 2, 4 or 8 for s = 0..3), an access is misaligned when (2^s − 1) AND vaddr is nonzero, and then out_err_mis is 1.
- R4: An aligned access to 0x80000000–0xBFFFFFFF in any mode other than kernel sets out_err_priv.
- R5: At most one of out_err_mis and out_err_priv is set; misalignment wins over privilege.
- R6: out_err_code is 00 with no error, 10 for an error on a store (kind 10), and 01 for an error on a fetch (kind 00), a load (kind 01) or kind 11.
- R7: For vaddr in 0x80000000–0xBFFFFFFF, out_mapped is 0 and out_paddr is vaddr AND 0x1FFFFFFF. Otherwise out_mapped is 1 and out_paddr equals vaddr.
- R8: out_uncached is 1 exactly when vaddr bits 31 and 29 are both 1.
- R9: in_ready equals (NOT out_valid) OR out_ready. A request accepted on a clock edge is presented with out_valid the cycle after. A result held while out_ready is 0 stays unchanged.
- R10: While rst_n is low, and right after it is released, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when in_valid is high |
| in_status | input | 32 | Processor status word |
| in_vaddr | input | 32 | Virtual address |
| in_size | input | 2 | Size code, byte count 2^code |
| in_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 treated as load |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mode | output | 2 | 00 kernel, 01 supervisor, 10 user, 11 illegal |
| out_err_mis | output | 1 | Misalignment error |
| out_err_priv | output | 1 | Privilege error |
| out_err_code | output | 2 | 00 none, 01 load/fetch address error, 10 store address error |
| out_paddr | output | 32 | Physical address (unmapped) or virtual address (mapped) |
| out_mapped | output | 1 | Request must go through the TLB |
| out_uncached | output | 1 | Request is uncacheable |

## Verification
On every cycle, the assertions check that the two error causes never appear together and that the error code agrees with them. They check that a privilege error only shows up on an unmapped request outside kernel mode, and that unmapped physical addresses have their top three bits cleared. They also check that a stalled result holds steady and that an accepted request yields a valid result one cycle later. The bench's scenarios are needed to show the actual mode decode for each override bit and field value. They also cover the alignment rule at each size, the window boundaries at 0x7FFFFFFF, 0x80000000, 0xBFFFFFFF and 0xC0000000, the uncached pattern in mapped space, and the store/load code split.

// File: rtl/access_gate.sv
module access_gate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_status,
  input  logic [31:0] in_vaddr,
  input  logic [1:0]  in_size,
  input  logic [1:0]  in_kind,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_mode,
  output logic        out_err_mis,
  output logic        out_err_priv,
  output logic [1:0]  out_err_code,
  output logic [31:0] out_paddr,
  output logic        out_mapped,
  output logic        out_uncached
);

  localparam logic [1:0] M_KERN  = 2'b00;
  localparam logic [1:0] M_SUPER = 2'b01;
  localparam logic [1:0] M_USER  = 2'b10;
  localparam logic [1:0] M_ILL   = 2'b11;
  localparam logic [1:0] K_STORE = 2'b10;

  logic [1:0] mode_d;
  logic [3:0] low_mask;
  logic       force_kern, mis_d, unmapped_d, priv_d;
  logic [1:0] code_d;
  logic [31:0] paddr_d;

  assign force_kern = in_status[28] | in_status[2] | in_status[1];

  always_comb begin
    if (force_kern || in_status[4:3] == 2'b00) mode_d = M_KERN;
    else if (in_status[4:3] == 2'b01)          mode_d = M_SUPER;
    else if (in_status[4:3] == 2'b10)          mode_d = M_USER;
    else                                       mode_d = M_ILL;
  end

  always_comb begin
    case (in_size)
      2'd0:    low_mask = 4'b0000;
      2'd1:    low_mask = 4'b0001;
      2'd2:    low_mask = 4'b0011;
      default: low_mask = 4'b0111;
    endcase
  end

  assign mis_d      = |(in_vaddr[3:0] & low_mask);
  assign unmapped_d = (in_vaddr[31:30] == 2'b10);
  assign priv_d     = unmapped_d && (mode_d != M_KERN) && !mis_d;
  assign code_d     = (mis_d || priv_d) ? ((in_kind == K_STORE) ? 2'b10 : 2'b01) : 2'b00;
  assign paddr_d    = unmapped_d ? {3'b000, in_vaddr[28:0]} : in_vaddr;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_mode     <= M_KERN;
      out_err_mis  <= 1'b0;
      out_err_priv <= 1'b0;
      out_err_code <= 2'b00;
      out_paddr    <= '0;
      out_mapped   <= 1'b0;
      out_uncached <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mode     <= mode_d;
        out_err_mis  <= mis_d;
        out_err_priv <= priv_d;
        out_err_code <= code_d;
        out_paddr    <= paddr_d;
        out_mapped   <= !unmapped_d;
        out_uncached <= in_vaddr[31] & in_vaddr[29];
      end
    end
  end

  a_r5_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_err_mis, out_err_priv}));

  a_r6_code_matches_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_err_code != 2'b00) == (out_err_mis || out_err_priv)) && (out_err_code != 2'b11));

  a_r4_priv_only_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err_priv) |-> (!out_mapped && out_mode != M_KERN));

  a_r7_unmapped_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mapped) |-> (out_paddr[31:29] == 3'b000));

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_paddr) && $stable(out_err_code) && $stable(out_mode)));

  a_r9_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: tb/test_access_gate.sv
module test_access_gate;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [31:0] in_status = 0, in_vaddr = 0;
  logic [1:0] in_size = 0, in_kind = 0;
  logic in_ready, out_valid, out_err_mis, out_err_priv, out_mapped, out_uncached;
  logic [1:0] out_mode, out_err_code;
  logic [31:0] out_paddr;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  bit m_valid = 0;
  logic [1:0] e_mode, e_code;
  bit e_mis, e_priv, e_map, e_unc;
  logic [31:0] e_pa;

  access_gate i_access_gate (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_accept();
    int bytes;
    bit ovr, unm;
    ovr = in_status[28] || in_status[2] || in_status[1];
    if (ovr || in_status[4:3] == 0) e_mode = 0;
    else e_mode = in_status[4:3];
    bytes = 1 << in_size;
    e_mis = ((in_vaddr % bytes) != 0);
    unm = (in_vaddr >= 32'h8000_0000) && (in_vaddr <= 32'hBFFF_FFFF);
    e_priv = !e_mis && unm && e_mode != 0;
    e_code = (e_mis || e_priv) ? ((in_kind == 2) ? 2'd2 : 2'd1) : 2'd0;
    e_map = !unm;
    e_pa = unm ? in_vaddr - 32'h8000_0000 - (in_vaddr >= 32'hA000_0000 ? 32'h2000_0000 : 0) : in_vaddr;
    e_unc = in_vaddr[31] && in_vaddr[29];
  endtask

  task automatic compare();
    chk(out_valid == m_valid, "R9", "out_valid", out_valid, m_valid);
    if (m_valid && out_valid) begin
      chk(out_mode == e_mode, "R1/R2", "mode", out_mode, e_mode);
      chk(out_err_mis == e_mis, "R3", "misalign", out_err_mis, e_mis);
      chk(out_err_priv == e_priv, "R4/R5", "priv", out_err_priv, e_priv);
      chk(out_err_code == e_code, "R6", "code", out_err_code, e_code);
      chk(out_mapped == e_map && out_paddr == e_pa, "R7", "paddr", {out_mapped, out_paddr}, {e_map, e_pa});
      chk(out_uncached == e_unc, "R8", "uncached", out_uncached, e_unc);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] st, input logic [31:0] va,
                      input logic [1:0] sz, input logic [1:0] kd, input bit rdy);
    @(negedge clk);
    compare();
    in_valid = v; in_status = st; in_vaddr = va; in_size = sz; in_kind = kd; out_ready = rdy;
    #0.5;
    chk(in_ready == (!m_valid || rdy), "R9", "in_ready", in_ready, !m_valid || rdy);
    if (!m_valid || rdy) begin
      m_valid = v;
      if (v) model_accept();
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R10", "valid in reset", out_valid, 0);
    @(negedge clk); rst_n = 1;
    chk(out_valid == 0, "R10", "valid after reset", out_valid, 0);
    // R1 overrides and field 00
    step(1, 32'h0000_0010, 32'h8000_0000, 2, 1, 1);
    step(1, 32'h1000_0018, 32'h8000_0004, 2, 1, 1);
    step(1, 32'h0000_0014, 32'h8000_0004, 2, 1, 1);
    step(1, 32'h0000_000A, 32'h8000_0004, 2, 1, 1);
    step(1, 32'h0000_0000, 32'h9FFF_FFFC, 2, 1, 1);
    // R2 field decode
    step(1, 32'h0000_0008, 32'h8000_0000, 0, 0, 1);
    step(1, 32'h0000_0010, 32'hBFFF_FFFF, 0, 2, 1);
    step(1, 32'h0000_0018, 32'hA000_0000, 2, 1, 1);
    // R3/R5 sizes and priority
    step(1, 32'h0000_0010, 32'h8000_0001, 1, 2, 1);
    step(1, 32'h0000_0000, 32'h0000_0006, 2, 0, 1);
    step(1, 32'h0000_0000, 32'h0000_0004, 3, 1, 1);
    step(1, 32'h0000_0000, 32'h0000_0008, 3, 3, 1);
    // R7/R8 window edges
    step(1, 32'h0000_0010, 32'h7FFF_FFFF, 0, 1, 1);
    step(1, 32'h0000_0010, 32'hC000_0000, 0, 1, 1);
    step(1, 32'h0000_0000, 32'hE123_4568, 2, 2, 1);
    step(1, 32'h0000_0000, 32'hA123_4567, 0, 2, 1);
    // R9 stall
    step(1, 32'h0000_0010, 32'h8000_0000, 2, 2, 0);
    step(1, 32'h0000_0000, 32'h1234_0000, 2, 1, 0);
    step(0, 32'h0000_0000, 32'h0, 0, 0, 1);
    step(0, 32'h0000_0000, 32'h0, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] va, st;
      va = $urandom;
      st = $urandom;
      if ($urandom % 2) st = st & 32'hEFFF_FFF9;
      if ($urandom % 3 == 0) va[31:30] = 2'b10;
      if ($urandom % 2) va[2:0] = 3'b000;
      step(($urandom % 4) != 0, st, va, 2'($urandom), 2'($urandom), ($urandom % 3) != 0);
    end
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule